// File: doc/BRIEF.md
# Sequential Signed Multiplier with Bit-Pair Recoding

This block multiplies two signed two's-complement operands of a configurable width, retiring one multiplier bit per clock. A single working register holds both the running partial sum (upper part, one bit wider than an operand) and the multiplier (lower part). Each iteration looks at the lowest multiplier bit together with a saved "previous" bit. From that pair it subtracts the multiplicand from the upper part, adds it, or leaves the upper part alone. The whole register then takes one arithmetic shift to the right. A run of ones in the multiplier therefore costs one subtraction where the run starts and one addition where it ends.

The controller has three named states. IDLE waits for a request. RUN performs the iterations. FIN marks completion for one cycle. The transitions are:
- IDLE to RUN on an accepted start (load).
- RUN to RUN while iterations remain (step).
- RUN to FIN on the last iteration (finish).
- FIN to RUN on a start (reload).
- FIN to IDLE otherwise (retire).

A start is accepted only when the block is not busy. The operands are captured in that same cycle. The product stays on its output until the next accepted start.

Top module: `booth_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: When `start` is high while `busy` is 0, `busy` is high for exactly WIDTH consecutive cycles, beginning on the cycle after the start edge.
- R3: `done` is high for exactly one cycle, in the cycle right after the last busy cycle. `done` and `busy` are never high together.
- R4: `product` equals the exact signed product of the captured `mcand` and `mplier`, over the full 2*WIDTH-bit range. This includes the most negative value times itself.
- R5: Bit-pair recoding, where the pair is (current multiplier bit, bit to its right) and the bit to the right of bit 0 is taken as 0. Pair (1,0) subtracts the multiplicand, pair (0,1) adds it, and pairs (0,0) and (1,1) only shift. For example, 4 × −9 gives −36 and −9 × −13 gives 117.
- R6: While `busy` is 1, `start` and operand changes are ignored. They affect neither the result nor the timing of the running operation.
- R7: From `done` until the next accepted start, `product` is held stable, whatever the operand inputs do.
- R8: A zero operand on either side gives a product of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiplication; accepted when not busy |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product, held until next start |

## Verification
The checker runs on every cycle. It enforces the WIDTH-cycle busy window, the single-cycle `done` that never overlaps `busy`, and a held `product` between operations. It also compares each completed result against a product computed from the operands captured at acceptance.

The exact recoding cases and the corner operands can only be shown by the bench's scenarios. These include the two worked examples, most-negative operands, zero, and alternating bit patterns. The same holds for the proof that stray starts and operand changes during a run leave the result untouched.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } step_op_t;

endpackage

// File: rtl/booth_mul_recode.sv
module booth_mul_recode
    import booth_mul_pkg::*;
(
    input  logic     cur_bit,
    input  logic     prev_bit,
    output step_op_t op
);

    always_comb begin
        unique case ({cur_bit, prev_bit})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/booth_mul_ctrl.sv
module booth_mul_ctrl
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(WIDTH) + 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    mul_state_t state_q, state_d;
    logic [CW-1:0] iter_q;
    logic          last_iter;

    assign last_iter = (iter_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_q <= '0;
        end else if (load) begin
            iter_q <= '0;
        end else if (step) begin
            iter_q <= iter_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last_iter) state_d = ST_FIN;
            ST_FIN:  state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_FIN: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/booth_mul_dp.sv
module booth_mul_dp
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product
);

    localparam int AW = WIDTH + 1;

    logic [AW-1:0]    upper_q;
    logic [WIDTH-1:0] lower_q;
    logic             prev_q;
    logic [AW-1:0]    mc_q;
    logic [AW-1:0]    sum;
    step_op_t         op;

    booth_mul_recode u_recode (
        .cur_bit (lower_q[0]),
        .prev_bit(prev_q),
        .op      (op)
    );

    always_comb begin
        unique case (op)
            OP_ADD:  sum = upper_q + mc_q;
            OP_SUB:  sum = upper_q - mc_q;
            default: sum = upper_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
            prev_q  <= 1'b0;
            mc_q    <= '0;
        end else if (load) begin
            upper_q <= '0;
            lower_q <= mplier;
            prev_q  <= 1'b0;
            mc_q    <= {mcand[WIDTH-1], mcand};
        end else if (step) begin
            upper_q <= {sum[AW-1], sum[AW-1:1]};
            lower_q <= {sum[0], lower_q[WIDTH-1:1]};
            prev_q  <= lower_q[0];
        end
    end

    assign product = {upper_q[WIDTH-1:0], lower_q};

endmodule

// File: rtl/booth_mul.sv
module booth_mul #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    logic load;
    logic step;

    booth_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .load (load),
        .step (step),
        .busy (busy),
        .done (done)
    );

    booth_mul_dp #(.WIDTH(WIDTH)) u_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .mcand  (mcand),
        .mplier (mplier),
        .product(product)
    );

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [WIDTH-1:0]   mcand,
    input logic [WIDTH-1:0]   mplier,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);

    localparam int CW = $clog2(WIDTH) + 2;

    logic                      accept;
    logic [CW-1:0]             busy_cnt;
    logic signed [2*WIDTH-1:0] expect_q;
    logic                      armed_q;

    assign accept = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            expect_q <= '0;
            armed_q  <= 1'b0;
        end else begin
            if (busy) busy_cnt <= busy_cnt + 1'b1;
            else      busy_cnt <= '0;
            if (accept) begin
                expect_q <= $signed({{WIDTH{mcand[WIDTH-1]}}, mcand}) *
                            $signed({{WIDTH{mplier[WIDTH-1]}}, mplier});
                armed_q  <= 1'b1;
            end
        end
    end

    // R2: accepted start makes the block busy next cycle
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R2: busy never exceeds WIDTH cycles and ends exactly at WIDTH
    p_busy_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt == CW'(WIDTH - 1)) |=> !busy);

    p_busy_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt < CW'(WIDTH - 1)) |=> busy);

    // R3: done follows busy falling, lasts one cycle, never overlaps busy
    p_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4: completed result matches product of captured operands
    p_product_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && armed_q) |-> (product == expect_q));

    // R7: result held while idle and no start accepted
    p_product_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> $stable(product));

endmodule

bind booth_mul booth_mul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mcand  (mcand),
    .mplier (mplier),
    .busy   (busy),
    .done   (done),
    .product(product)
);

// File: tb/booth_mul_test.sv
`timescale 1ns/1ps
module booth_mul_test;

    localparam int W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [W-1:0]       mcand = '0;
    logic [W-1:0]       mplier = '0;
    logic               busy;
    logic               done;
    logic [2*W-1:0]     product;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    booth_mul #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        longint sa;
        longint sb;
        longint p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        p  = sa * sb;
        return p[2*W-1:0];
    endfunction

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one operation; optionally disturbs inputs while busy (R6).
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit disturb, input string req);
        int cycles;
        int busy_cnt;
        logic [2*W-1:0] exp;
        exp = ref_mul(a, b);
        @(negedge clk);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        busy_cnt = 0;
        while (!done && cycles < 4*W) begin
            if (busy) busy_cnt++;
            if (disturb) begin
                mcand  = W'($urandom);
                mplier = W'($urandom);
                start  = 1'($urandom);
            end
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        check("R2", busy_cnt == W, busy_cnt, W);
        check("R3", done && !busy && cycles == W + 1, cycles, W + 1);
        check(req, product == exp, $signed(product), $signed(exp));
        @(negedge clk);
        check("R3", !done, done, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        #1;
        check("R1", !busy && !done && product == '0, product, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", !busy && !done && product == '0, product, 0);

        // R5 worked examples
        run_op(W'(4), W'(-9), 1'b0, "R5");
        check("R5", $signed(product) == -36, $signed(product), -36);
        run_op(W'(-9), W'(-13), 1'b0, "R5");
        check("R5", $signed(product) == 117, $signed(product), 117);
        run_op(8'b0101_0101, 8'b1010_1010, 1'b0, "R5");
        run_op(8'h7f, 8'hff, 1'b0, "R5");

        // R4 range corners
        run_op(8'h80, 8'h80, 1'b0, "R4");
        run_op(8'h80, 8'h7f, 1'b0, "R4");
        run_op(8'h7f, 8'h7f, 1'b0, "R4");
        run_op(8'hff, 8'hff, 1'b0, "R4");

        // R8 zero operands
        run_op(8'h00, 8'h93, 1'b0, "R8");
        run_op(8'h93, 8'h00, 1'b0, "R8");

        // R7 hold after completion
        begin
            logic [2*W-1:0] held;
            held = product;
            for (int i = 0; i < 6; i++) begin
                mcand = W'($urandom); mplier = W'($urandom);
                @(negedge clk);
                check("R7", product == held && !done && !busy, product, held);
            end
        end

        // R6 disturbed runs
        for (int i = 0; i < 20; i++)
            run_op(W'($urandom), W'($urandom), 1'b1, "R6");

        // R4 random
        for (int i = 0; i < 300; i++)
            run_op(W'($urandom), W'($urandom), 1'b0, "R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule